// File: doc/BRIEF.md
# Double-Precision NaN Quieting Unit

This unit inspects one 64-bit binary64 floating-point operand per cycle and sorts it into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. A signaling NaN is turned into a quiet NaN and the invalid-operation flag is raised alongside it. Every other operand comes out unchanged. A single mode input selects which meaning of the top fraction bit is in force. In the 2008 meaning a set top fraction bit marks a quiet NaN. In the legacy meaning a set top fraction bit marks a signaling NaN.

The unit sits ahead of a floating-point pipeline, or inside an operand-fetch stage, where signaling NaNs must be neutralised before use. Results are registered. The output strobe repeats the input strobe one cycle later, and the output registers hold their contents while no new operand is offered. In legacy mode, clearing the top fraction bit could leave an all-zero fraction, which would encode infinity. For that case the unit sets the next fraction bit down instead, so the result is still a NaN.

Top module: `dnq_top`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, outValid, outClass, result and invalidFlag are all zero.
- R2: outValid equals the value inValid had at the previous rising clock edge.
- R3: outClass encodes the operand class as follows: 0 for zero (exponent field bits 62:52 all zero, fraction bits 51:0 zero), 1 for subnormal (exponent zero, fraction nonzero), 2 for normal, 3 for infinity (exponent all ones, fraction zero), 4 for quiet NaN and 5 for signaling NaN (exponent all ones, fraction nonzero).
- R4: A NaN is signaling exactly when nanMode2008 XOR operand bit 51 is 1. With nanMode2008 = 1, a clear bit 51 means signaling. With nanMode2008 = 0, a set bit 51 means signaling.
- R5: In 2008 mode a signaling NaN is returned with bit 51 set and every other bit unchanged.
- R6: In legacy mode a signaling NaN is returned with bit 51 cleared. If the remaining fraction bits 50:0 are nonzero, every other bit is unchanged.
- R7: In legacy mode, if fraction bits 50:0 of a signaling NaN are all zero, the result has bit 51 cleared and bit 50 set. Sign and exponent are unchanged.
- R8: invalidFlag is 1 for a valid output exactly when the operand was a signaling NaN.
- R9: Quiet NaNs, infinities, normals, subnormals and zeros are returned bit-for-bit unchanged.
- R10: A cycle with inValid low leaves outClass, result and invalidFlag at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| operand | input | 64 | Binary64 operand |
| nanMode2008 | input | 1 | 1 selects the 2008 quiet-bit meaning, 0 selects the legacy meaning |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outClass | output | 3 | Class code of the captured operand |
| result | output | 64 | Operand, quieted if it was signaling |
| invalidFlag | output | 1 | Invalid-operation flag |

## Verification
The operands are directed ones at the edges of each class: both zeros, the smallest and largest subnormals, the smallest and largest normals, both infinities, and NaNs whose fraction is only bit 51, only bit 50, only bit 0, or full. Each NaN is sent under both mode values, which separates the two quiet-bit meanings. The legacy case with only bit 51 set is the one that reaches the infinity fix-up, while NaNs carrying a payload show whether the other fraction bits survive. A stream of pseudo-random operands, with gaps in the strobe, then checks pass-through and the hold behaviour between operands.

// File: rtl/dnq_pkg.sv
package dnq_pkg;

  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fpClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new operand
    logic quieten;  // rewrite the operand as a quiet NaN
  } ctrlStrobe_t;

endpackage

// File: rtl/dnq_classify.sv
module dnq_classify
  import dnq_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int DW = 1 + EW + FW
) (
  input  logic [DW-1:0] value,
  input  logic          mode2008,
  output fpClass_t      cls
);
  logic [EW-1:0] expField;
  logic [FW-1:0] fracField;
  logic expOnes, expZero, fracZero, sigTest;

  assign expField  = value[DW-2 -: EW];
  assign fracField = value[FW-1:0];
  assign expOnes   = &expField;
  assign expZero   = ~|expField;
  assign fracZero  = ~|fracField;
  // signaling when mode disagrees with the top fraction bit's sense
  assign sigTest   = mode2008 ^ fracField[FW-1];

  always_comb begin
    if (expZero)      cls = fracZero ? CLS_ZERO : CLS_SUB;
    else if (!expOnes) cls = CLS_NORM;
    else if (fracZero) cls = CLS_INF;
    else               cls = sigTest ? CLS_SNAN : CLS_QNAN;
  end
endmodule

// File: rtl/dnq_ctrl.sv
module dnq_ctrl
  import dnq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  fpClass_t    cls,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load    = inValid;
  assign strobe.quieten = inValid && (cls == CLS_SNAN);

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));
endmodule

// File: rtl/dnq_datapath.sv
module dnq_datapath
  import dnq_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int DW = 1 + EW + FW
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [DW-1:0] operand,
  input  logic          mode2008,
  input  fpClass_t      cls,
  output logic [DW-1:0] result,
  output fpClass_t      outClass,
  output logic          invalidFlag
);
  localparam int QBIT = FW - 1;
  localparam int FIXBIT = FW - 2;

  logic [DW-1:0] quietVal;
  logic [DW-1:0] nextVal;

  always_comb begin
    quietVal = operand;
    if (mode2008) begin
      quietVal[QBIT] = 1'b1;
    end else begin
      quietVal[QBIT] = 1'b0;
      // keep it a NaN: an empty fraction would read as infinity
      if (~|operand[QBIT-1:0]) quietVal[FIXBIT] = 1'b1;
    end
    nextVal = strobe.quieten ? quietVal : operand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      outClass    <= CLS_ZERO;
      invalidFlag <= 1'b0;
    end else if (strobe.load) begin
      result      <= nextVal;
      outClass    <= cls;
      invalidFlag <= strobe.quieten;
    end
  end

  // R7
  quiet_is_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> ((&result[DW-2 -: EW]) && (|result[FW-1:0])));
  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.quieten) |=> (result == $past(operand)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !strobe.load) |=> ($stable(result) && $stable(invalidFlag)));
  // R8
  flag_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag == (outClass == CLS_SNAN));
endmodule

// File: rtl/dnq_top.sv
module dnq_top
  import dnq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] operand,
  input  logic        nanMode2008,
  output logic        outValid,
  output logic [2:0]  outClass,
  output logic [63:0] result,
  output logic        invalidFlag
);
  fpClass_t    clsNow;
  fpClass_t    clsReg;
  ctrlStrobe_t strobe;

  dnq_classify u_classify (
    .value    (operand),
    .mode2008 (nanMode2008),
    .cls      (clsNow)
  );

  dnq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .cls      (clsNow),
    .strobe   (strobe),
    .outValid (outValid)
  );

  dnq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .operand     (operand),
    .mode2008    (nanMode2008),
    .cls         (clsNow),
    .result      (result),
    .outClass    (clsReg),
    .invalidFlag (invalidFlag)
  );

  assign outClass = clsReg;
endmodule

// File: tb/sim_dnq_top.sv
module sim_dnq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic        nanMode2008 = 1'b0;
  logic        outValid;
  logic [2:0]  outClass;
  logic [63:0] result;
  logic        invalidFlag;

  int checks = 0;
  int errors = 0;

  // model state: what the outputs must show at the next sample
  logic        mValid = 1'b0;
  logic [2:0]  mClass = 3'd0;
  logic [63:0] mRes = '0;
  logic        mInv = 1'b0;
  logic [63:0] lfsr = 64'hACE1_2345_6789_BEEF;

  always #5 clk = ~clk;

  dnq_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .nanMode2008(nanMode2008), .outValid(outValid), .outClass(outClass),
    .result(result), .invalidFlag(invalidFlag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: returns {class, invalid, value}
  task automatic refModel(input logic [63:0] v, input logic m2008,
                          output logic [2:0] c, output logic inv, output logic [63:0] r);
    int unsigned e = int'(v[62:52]);
    logic [51:0] f = v[51:0];
    logic sig;
    r = v; inv = 1'b0;
    if (e == 0) c = (f == 0) ? 3'd0 : 3'd1;
    else if (e != 2047) c = 3'd2;
    else if (f == 0) c = 3'd3;
    else begin
      sig = m2008 ? (f[51] == 1'b0) : (f[51] == 1'b1);
      c = sig ? 3'd5 : 3'd4;
      if (sig) begin
        inv = 1'b1;
        if (m2008) r[51] = 1'b1;
        else begin
          r[51] = 1'b0;
          if (r[50:0] == 0) r[50] = 1'b1;
        end
      end
    end
  endtask

  function automatic string resTag(input logic [2:0] c, input logic m2008, input logic [63:0] r);
    if (c != 3'd5) return "R9";
    if (m2008) return "R5";
    if (r[49:0] == 0 && r[50]) return "R7/R6";
    return "R6";
  endfunction

  // compare outputs, then apply the next stimulus and advance the model
  task automatic step(input logic vld, input logic [63:0] v, input logic m2008);
    logic [2:0] c; logic inv; logic [63:0] r;
    @(negedge clk);
    chk("R2 outValid", {63'd0, outValid}, {63'd0, mValid});
    chk(mValid ? "R3/R4 outClass" : "R10 outClass held", {61'd0, outClass}, {61'd0, mClass});
    chk(mValid ? "R8 invalidFlag" : "R10 invalidFlag held", {63'd0, invalidFlag}, {63'd0, mInv});
    chk(mValid ? resTag(mClass, m2008 ^ m2008 ^ nanMode2008, mRes) : "R10 result held", result, mRes);
    inValid = vld; operand = v; nanMode2008 = m2008;
    mValid = vld;
    if (vld) begin
      refModel(v, m2008, c, inv, r);
      mClass = c; mInv = inv; mRes = r;
    end
  endtask

  task automatic bothModes(input logic [63:0] v);
    step(1'b1, v, 1'b1);
    step(1'b1, v, 1'b0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", {63'd0, outValid}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 outClass", {61'd0, outClass}, 64'd0);
    chk("R1 invalidFlag", {63'd0, invalidFlag}, 64'd0);
    rstN = 1'b1;
    // zeros, subnormals, normals, infinities (R3, R9)
    bothModes(64'h0000_0000_0000_0000);
    bothModes(64'h8000_0000_0000_0000);
    bothModes(64'h0000_0000_0000_0001);
    bothModes(64'h800F_FFFF_FFFF_FFFF);
    bothModes(64'h0010_0000_0000_0000);
    bothModes(64'h7FEF_FFFF_FFFF_FFFF);
    bothModes(64'h7FF0_0000_0000_0000);
    bothModes(64'hFFF0_0000_0000_0000);
    // NaNs under both senses of bit 51 (R4, R5, R6, R7)
    bothModes(64'h7FF8_0000_0000_0000); // legacy: fix-up case R7
    bothModes(64'hFFF8_0000_0000_0000);
    bothModes(64'h7FF4_0000_0000_0000);
    bothModes(64'h7FF0_0000_0000_0001);
    bothModes(64'h7FFF_FFFF_FFFF_FFFF);
    bothModes(64'hFFF8_0000_0000_0001);
    // gaps: R10 hold
    step(1'b0, 64'h7FF8_0000_0000_0000, 1'b1);
    step(1'b0, 64'h0000_0000_0000_0000, 1'b0);
    // pseudo-random stream, biased toward NaN exponents
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      v = lfsr;
      if (lfsr[5:4] == 2'b00) v[62:52] = 11'h7FF;
      if (lfsr[7:6] == 2'b00) v[50:0] = '0;
      step(lfsr[9:8] != 2'b00, v, lfsr[11]);
    end
    step(1'b0, 64'd0, 1'b0);
    step(1'b0, 64'd0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule